// File: doc/BRIEF.md
# USB Host Status and Run-Control Register

This block holds the status and run-control state of a USB 1.1 host controller that walks a frame list of transfer descriptors. A separate schedule engine reports what happens on the bus through single-cycle event pulses. This block turns those pulses into sticky status flags, which software reads and clears by writing ones. It also holds the run bit and the global-suspend bit that software writes. When the controller hits a fatal error, the block drops the run bit on its own.

Several outputs go back to the rest of the controller. A halted flag rises once the controller is stopped and no transaction is still in flight. A start-of-frame counter reset is held while the controller is stopped outside debug mode, so that a restart begins again at the frame list index. An interrupt request combines the five event flags, each through its own enable.

Top module: `usbh_status_ctl`

## Requirements
- R1: After reset the status read value is 0x0020 (only the halted flag set), the run and suspend bits read 0, and the interrupt request is low.
- R2: Status bits 15:6 always read 0, and writing ones to them changes nothing.
- R3: Writing a 1 to a defined status bit clears it in the next cycle. Writing a 0 leaves it unchanged.
- R4: When a hardware set event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The halted flag (bit 5) is set one cycle after a cycle in which the run bit is 0 and `xact_busy` is low. It is not set while a transaction is still busy.
- R6: A descriptor consistency failure sets bit 4 and clears the run bit in the next cycle, even if software writes run=1 in that same cycle.
- R7: A host bus error sets bit 3 and clears the run bit in the next cycle, even if software writes run=1 in that same cycle.
- R8: A resume event sets bit 2 only while the suspend bit is 1. Outside suspend it is ignored.
- R9: A completion with `td_err` set sets bit 1. If `td_ioc` is also set, bits 1 and 0 are set in the same cycle.
- R10: Bit 0 is set by a completion with `td_ioc`, or by a completion with both `td_short` and `td_spd`. A short completion without `td_spd` does not set it.
- R11: `sof_rst` is high whenever the run bit is 0 and `dbg_mode` is 0. It is low while running or while in debug mode.
- R12: `irq` is the OR of status bits 4:0, each ANDed with `int_en` at the same index. It stays high until software clears the causing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sts_wr_en | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wr_data | input | 16 | Status write data |
| cmd_wr_en | input | 1 | Command write strobe |
| cmd_run | input | 1 | Run bit value to write |
| cmd_susp | input | 1 | Global-suspend bit value to write |
| dbg_mode | input | 1 | Debug mode: frame counter is not reset on stop |
| xact_busy | input | 1 | A bus transaction is in progress |
| xact_done | input | 1 | Completion pulse for a transaction |
| td_ioc | input | 1 | Completed descriptor asked for an interrupt |
| td_err | input | 1 | Completion ended in error |
| td_short | input | 1 | Actual length below maximum length |
| td_spd | input | 1 | Short-packet detection enabled in descriptor |
| ev_consist | input | 1 | Descriptor consistency failure pulse |
| ev_bus_err | input | 1 | Host bus error pulse (parity or abort) |
| ev_resume | input | 1 | Resume signalling seen from a device |
| int_en | input | 5 | Per-flag interrupt enables for bits 4:0 |
| sts_rdata | output | 16 | Status read value |
| run_flag | output | 1 | Current run bit |
| susp_flag | output | 1 | Current global-suspend bit |
| halted | output | 1 | Halted flag (status bit 5) |
| sof_rst | output | 1 | Start-of-frame counter reset |
| irq | output | 1 | Interrupt request |

## Verification
Each event or write applied before a clock edge shows up in `sts_rdata`, `run_flag` and `susp_flag` just after that edge, and `irq` follows in the same cycle. `sof_rst` therefore follows the run bit in the cycle after a command write or a fatal event. The halted flag needs one more edge: it appears one cycle after the first cycle in which the controller is both stopped and idle. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next one, so every check samples exactly the first cycle in which a result is due. For the halted flag it also samples the earlier cycle, where the flag must still be low.

// File: rtl/usbh_sts_pkg.sv
// Package: shared bit positions, widths and the event bundle for the
// USB host status and run-control block.
// Assumes: every event field is a one-cycle pulse qualified by the schedule engine.
package usbh_sts_pkg;
    localparam int STS_W   = 16;              // architectural register width
    localparam int NFLAG   = 6;               // defined status flags
    localparam int NIRQ    = 5;               // flags that can raise the interrupt
    localparam int B_INT   = 0;               // normal completion interrupt
    localparam int B_ERR   = 1;               // error completion interrupt
    localparam int B_RSM   = 2;               // resume seen in suspend
    localparam int B_HSE   = 3;               // host bus error
    localparam int B_HPE   = 4;               // descriptor consistency failure
    localparam int B_HLT   = 5;               // controller halted

    typedef struct packed {
        logic done;
        logic ioc;
        logic err;
        logic shrt;
        logic spd;
        logic cfail;
        logic berr;
        logic rsm;
    } sched_ev_t;
endpackage

// File: rtl/usbh_w1c_bit.sv
// Module: one sticky status flag. A hardware set wins over a software
// write-one-to-clear in the same cycle.
// Assumes: set and clr are already qualified by the caller.
module usbh_w1c_bit #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag storage with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= RST_VAL;
        else if (set)    q <= 1'b1;
        else if (clr)    q <= 1'b0;
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
    // R3
    w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set) |=> $stable(q));
endmodule

// File: rtl/usbh_sts_set.sv
// Module: turns schedule events and controller state into per-flag
// set requests for the status register.
// Assumes: completion qualifiers (ioc, err, shrt, spd) are valid with done.
module usbh_sts_set
    import usbh_sts_pkg::*;
(
    input  sched_ev_t         ev,
    input  logic              susp_q,
    input  logic              run_q,
    input  logic              busy,
    output logic [NFLAG-1:0]  set_req
);
    // Decode each flag's set condition.
    always_comb begin
        set_req        = '0;
        set_req[B_INT] = ev.done & (ev.ioc | (ev.shrt & ev.spd));
        set_req[B_ERR] = ev.done & ev.err;
        set_req[B_RSM] = ev.rsm & susp_q;
        set_req[B_HSE] = ev.berr;
        set_req[B_HPE] = ev.cfail;
        set_req[B_HLT] = ~run_q & ~busy;
    end
endmodule

// File: rtl/usbh_run_ctl.sv
// Module: run and global-suspend command bits, the hardware stop on fatal
// errors, and the start-of-frame counter reset.
// Assumes: fatal is a one-cycle pulse; fatal overrides a same-cycle write.
module usbh_run_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic run_in,
    input  logic susp_in,
    input  logic fatal,
    input  logic dbg_mode,
    output logic run_q,
    output logic susp_q,
    output logic sof_rst
);
    // Run bit: software writes, hardware clears on fatal error.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (fatal)  run_q <= 1'b0;
        else if (wr_en)  run_q <= run_in;
    end

    // Suspend bit: software-written only.
    always_ff @(posedge clk) begin
        if (!rst_n)      susp_q <= 1'b0;
        else if (wr_en)  susp_q <= susp_in;
    end

    // Hold the frame counter in reset while stopped, except in debug mode.
    always_comb sof_rst = ~run_q & ~dbg_mode;

    // R6
    fatal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> !run_q);
    // R11
    sof_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> !sof_rst);
endmodule

// File: rtl/usbh_irq_gen.sv
// Module: interrupt request as the enabled OR of the event flags.
// Assumes: flags are sticky, so the request is level and holds until cleared.
module usbh_irq_gen #(
    parameter int N = 5
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    output logic         irq
);
    // Reduce the enabled flags to one request.
    always_comb irq = |(flags & en);
endmodule

// File: rtl/usbh_status_ctl.sv
// Module: top of the USB host status and run-control register. Holds the
// sticky status flags, the run and suspend bits, and derives halted,
// start-of-frame reset and interrupt request.
// Assumes: synchronous active-low reset; event inputs are one-cycle pulses.
module usbh_status_ctl
    import usbh_sts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sts_wr_en,
    input  logic [STS_W-1:0]  sts_wr_data,
    input  logic              cmd_wr_en,
    input  logic              cmd_run,
    input  logic              cmd_susp,
    input  logic              dbg_mode,
    input  logic              xact_busy,
    input  logic              xact_done,
    input  logic              td_ioc,
    input  logic              td_err,
    input  logic              td_short,
    input  logic              td_spd,
    input  logic              ev_consist,
    input  logic              ev_bus_err,
    input  logic              ev_resume,
    input  logic [NIRQ-1:0]   int_en,
    output logic [STS_W-1:0]  sts_rdata,
    output logic              run_flag,
    output logic              susp_flag,
    output logic              halted,
    output logic              sof_rst,
    output logic              irq
);
    localparam int RSV_W = STS_W - NFLAG;

    sched_ev_t         ev;
    logic [NFLAG-1:0]  set_req;
    logic [NFLAG-1:0]  flag_q;
    logic              run_q;
    logic              susp_q;
    logic              unused_rsv;

    // Bundle the event pins.
    always_comb begin
        ev.done  = xact_done;
        ev.ioc   = td_ioc;
        ev.err   = td_err;
        ev.shrt  = td_short;
        ev.spd   = td_spd;
        ev.cfail = ev_consist;
        ev.berr  = ev_bus_err;
        ev.rsm   = ev_resume;
    end

    // Reserved write bits have no function.
    always_comb unused_rsv = ^sts_wr_data[STS_W-1:NFLAG];

    usbh_run_ctl u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmd_wr_en),
        .run_in   (cmd_run),
        .susp_in  (cmd_susp),
        .fatal    (ev_consist | ev_bus_err),
        .dbg_mode (dbg_mode),
        .run_q    (run_q),
        .susp_q   (susp_q),
        .sof_rst  (sof_rst)
    );

    usbh_sts_set u_set (
        .ev      (ev),
        .susp_q  (susp_q),
        .run_q   (run_q),
        .busy    (xact_busy),
        .set_req (set_req)
    );

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            usbh_w1c_bit #(.RST_VAL(i == B_HLT)) u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (set_req[i]),
                .clr   (sts_wr_en & sts_wr_data[i]),
                .q     (flag_q[i])
            );
        end
    endgenerate

    usbh_irq_gen #(.N(NIRQ)) u_irq (
        .flags (flag_q[NIRQ-1:0]),
        .en    (int_en),
        .irq   (irq)
    );

    // Drive the register view and status pins.
    always_comb begin
        sts_rdata = {{RSV_W{1'b0}}, flag_q};
        run_flag  = run_q;
        susp_flag = susp_q;
        halted    = flag_q[B_HLT];
    end

    // R5
    halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[B_HLT]) |-> $past(!run_q && !xact_busy));
    // R8
    resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[B_RSM]) |-> $past(susp_q));
    // R7
    bus_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_err |=> (flag_q[B_HSE] && !run_q));
endmodule

// File: tb/usbh_status_ctl_tb.sv
module usbh_status_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sts_wr_en = 1'b0;
    logic [15:0] sts_wr_data = '0;
    logic        cmd_wr_en = 1'b0, cmd_run = 1'b0, cmd_susp = 1'b0;
    logic        dbg_mode = 1'b0, xact_busy = 1'b0, xact_done = 1'b0;
    logic        td_ioc = 1'b0, td_err = 1'b0, td_short = 1'b0, td_spd = 1'b0;
    logic        ev_consist = 1'b0, ev_bus_err = 1'b0, ev_resume = 1'b0;
    logic [4:0]  int_en = 5'h1F;
    logic [15:0] sts_rdata;
    logic        run_flag, susp_flag, halted, sof_rst, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    usbh_status_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
        .cmd_wr_en(cmd_wr_en), .cmd_run(cmd_run), .cmd_susp(cmd_susp),
        .dbg_mode(dbg_mode), .xact_busy(xact_busy), .xact_done(xact_done),
        .td_ioc(td_ioc), .td_err(td_err), .td_short(td_short), .td_spd(td_spd),
        .ev_consist(ev_consist), .ev_bus_err(ev_bus_err), .ev_resume(ev_resume),
        .int_en(int_en), .sts_rdata(sts_rdata), .run_flag(run_flag),
        .susp_flag(susp_flag), .halted(halted), .sof_rst(sof_rst), .irq(irq)
    );

    // Advance one edge, sample 1 ns after it, and drop all pulses.
    task automatic cyc();
        @(posedge clk);
        #1;
        sts_wr_en = 1'b0; sts_wr_data = '0; cmd_wr_en = 1'b0;
        xact_done = 1'b0; td_ioc = 1'b0; td_err = 1'b0; td_short = 1'b0;
        td_spd = 1'b0; ev_consist = 1'b0; ev_bus_err = 1'b0; ev_resume = 1'b0;
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic cmd_wr(logic r, logic s);
        cmd_wr_en = 1'b1; cmd_run = r; cmd_susp = s;
    endtask

    task automatic clear_all();
        sts_wr_en = 1'b1; sts_wr_data = 16'h003F; cyc();
    endtask

    task automatic t_reset();
        chk("R1 status", sts_rdata, 16'h0020);
        chk("R1 run", {15'd0, run_flag}, 16'd0);
        chk("R1 susp", {15'd0, susp_flag}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R11 sof_rst stopped", {15'd0, sof_rst}, 16'd1);
    endtask

    task automatic t_start();
        cmd_wr(1'b1, 1'b0); cyc();
        chk("R11 sof_rst running", {15'd0, sof_rst}, 16'd0);
        sts_wr_en = 1'b1; sts_wr_data = 16'h0000; cyc();
        chk("R3 write 0 keeps halted", sts_rdata, 16'h0020);
        sts_wr_en = 1'b1; sts_wr_data = 16'hFFE0; cyc();
        chk("R3 halted cleared", sts_rdata, 16'h0000);
        sts_wr_en = 1'b1; sts_wr_data = 16'hFFC0; cyc();
        chk("R2 reserved bits", sts_rdata, 16'h0000);
    endtask

    task automatic t_ioc();
        xact_done = 1'b1; td_ioc = 1'b1; cyc();
        chk("R10 ioc sets bit0", sts_rdata, 16'h0001);
        chk("R12 irq on bit0", {15'd0, irq}, 16'd1);
        cyc();
        chk("R12 irq held", {15'd0, irq}, 16'd1);
        sts_wr_en = 1'b1; sts_wr_data = 16'h0001; cyc();
        chk("R3 bit0 cleared", sts_rdata, 16'h0000);
        chk("R12 irq released", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_short();
        xact_done = 1'b1; td_short = 1'b1; cyc();
        chk("R10 short without detect", sts_rdata, 16'h0000);
        xact_done = 1'b1; td_short = 1'b1; td_spd = 1'b1; cyc();
        chk("R10 short with detect", sts_rdata, 16'h0001);
        clear_all();
    endtask

    task automatic t_err();
        xact_done = 1'b1; td_err = 1'b1; cyc();
        chk("R9 error only", sts_rdata, 16'h0002);
        clear_all();
        xact_done = 1'b1; td_err = 1'b1; td_ioc = 1'b1; cyc();
        chk("R9 error with ioc", sts_rdata, 16'h0003);
        clear_all();
    endtask

    task automatic t_setwins();
        xact_done = 1'b1; td_ioc = 1'b1; cyc();
        xact_done = 1'b1; td_ioc = 1'b1; sts_wr_en = 1'b1; sts_wr_data = 16'h0001; cyc();
        chk("R4 set beats clear", sts_rdata, 16'h0001);
        clear_all();
    endtask

    task automatic t_mask();
        int_en = 5'b11101;
        xact_done = 1'b1; td_err = 1'b1; cyc();
        chk("R12 masked bit1", {15'd0, irq}, 16'd0);
        int_en = 5'h1F; #1;
        chk("R12 enabled bit1", {15'd0, irq}, 16'd1);
        clear_all();
    endtask

    task automatic t_resume();
        ev_resume = 1'b1; cyc();
        chk("R8 resume outside suspend", sts_rdata, 16'h0000);
        cmd_wr(1'b1, 1'b1); cyc();
        chk("R8 suspend bit", {15'd0, susp_flag}, 16'd1);
        ev_resume = 1'b1; cyc();
        chk("R8 resume in suspend", sts_rdata, 16'h0004);
        cmd_wr(1'b1, 1'b0); cyc();
        clear_all();
    endtask

    task automatic t_consist();
        xact_busy = 1'b1;
        ev_consist = 1'b1; cmd_wr(1'b1, 1'b0); cyc();
        chk("R6 run cleared over write", {15'd0, run_flag}, 16'd0);
        chk("R6 process error set", sts_rdata, 16'h0010);
        chk("R11 sof_rst after stop", {15'd0, sof_rst}, 16'd1);
        cyc();
        chk("R5 no halt while busy", {15'd0, halted}, 16'd0);
        xact_busy = 1'b0; cyc();
        chk("R5 halt after idle", sts_rdata, 16'h0030);
        cmd_wr(1'b1, 1'b0); cyc();
        clear_all();
        chk("R3 clear after restart", sts_rdata, 16'h0000);
    endtask

    task automatic t_bus_err();
        ev_bus_err = 1'b1; cmd_wr(1'b1, 1'b0); cyc();
        chk("R7 run cleared", {15'd0, run_flag}, 16'd0);
        chk("R7 host error set", sts_rdata & 16'h001F, 16'h0008);
        dbg_mode = 1'b1; #1;
        chk("R11 debug keeps counter", {15'd0, sof_rst}, 16'd0);
        dbg_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_start();
        t_ioc();
        t_short();
        t_err();
        t_setwins();
        t_mask();
        t_resume();
        t_consist();
        t_bus_err();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule